// File: doc/BRIEF.md
# ATA Device Task-File and Interrupt Controller

This block is the device-side register set of an ATA task file. A host reads and writes the error/feature, count, byte-count low and high, device, status/command and alternate-status/control registers through a single-cycle register port. Writing the command register is decoded here. NOP aborts whatever is running, device reset reloads the power-on values, set-features completes at once, and packet opens a command phase. The packet phase is then handed to an external packet engine.

The packet engine receives a one-cycle start pulse. It then reports three events: it has taken the command bytes, it wants an interrupt, and it has finished. The block keeps the one pending-interrupt flag. It drives a registered host interrupt line that shows this flag only while the control register's disable bit is clear.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After synchronous reset: error=0x01, count=0x01, byte-count low=0x14, byte-count high=0xEB, status=0x00, device=0x00, irq_o=0, pkt_start_o=0, was_reset_o=1.
- R2: Register addresses: 0 reads error and writes feature, 1 count, 2 byte-count low, 3 byte-count high, 4 device, 5 reads status and writes command, 6 reads alternate status and writes control, 7 reads 0x00. Count, byte-count low/high and device read back what was written.
- R3: Writing any value to the command register clears the pending interrupt, unless that same command raises it again.
- R4: Command 0x00 (NOP) sets status=0x51 and error=0x04, returns to idle and raises the interrupt.
- R5: Command 0x08 (device reset) reloads the R1 register values, sets was_reset_o and clears the pending interrupt. The control register keeps its value.
- R6: Command 0xEF (set-features) sets status=0x50, error=0x00 and byte-count low and high to 0x00, and raises the interrupt. The feature and count values do not matter.
- R7: Command 0xA0 (packet) sets status=0x58, error=feature[1:0] and count=0x01. It pulses pkt_start_o for exactly one cycle after the write.
- R8: In the command phase, pkt_taken_i sets status bit 7 (BSY), clears bit 3 (DRQ) and moves to busy. In busy, pkt_done_i sets status=0x50 and count=0x03, returns to idle, clears was_reset_o and raises the interrupt.
- R9: pkt_irq_i raises the pending interrupt. irq_o is registered and follows the pending flag one clock after the event.
- R10: A read of status (address 5) clears the pending interrupt only when status bit 7 (BSY) is 0. A read of alternate status (address 6) never clears it.
- R11: A command code other than 0x00, 0x08, 0xA0 or 0xEF leaves every task-file register unchanged.
- R12: Control bit 1 disables the interrupt output. Setting it while an interrupt is pending drops irq_o at the next clock. Clearing it raises irq_o at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 8 | Read data, combinational from the addressed register |
| pkt_start_o | output | 1 | One-cycle pulse: packet command accepted |
| pkt_taken_i | input | 1 | Packet engine has taken the command bytes |
| pkt_irq_i | input | 1 | Packet engine interrupt request |
| pkt_done_i | input | 1 | Packet engine has finished the command |
| was_reset_o | output | 1 | Set by reset, cleared when a packet command completes |
| irq_o | output | 1 | Host interrupt line, registered level |

## Verification
The embedded properties check these on every cycle: the register results of NOP, set-features and packet writes; that unknown codes leave status and error alone; that every raise sets the pending flag; that clears without a raise drop it; and that a status read with BSY set keeps it. The bench scenarios cover the rest. They show the reset values and the exact reset-command values, the retained control bit, the register read-back paths, and the packet handshake order from start pulse through taken and done. They also show the one-clock visibility of irq_o when the disable bit toggles.

// File: rtl/ata_tf_pkg.sv
// Package: shared widths, register addresses, command codes and constants
// for the ATA task-file controller. Assumes an 8-bit task file.
package ata_tf_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_BUSY = 2'd2
    } phase_t;

    // register addresses
    localparam logic [AW-1:0] A_ERRFEAT = 3'd0;
    localparam logic [AW-1:0] A_COUNT   = 3'd1;
    localparam logic [AW-1:0] A_BCLO    = 3'd2;
    localparam logic [AW-1:0] A_BCHI    = 3'd3;
    localparam logic [AW-1:0] A_DEVICE  = 3'd4;
    localparam logic [AW-1:0] A_STATCMD = 3'd5;
    localparam logic [AW-1:0] A_ALTCTL  = 3'd6;

    // command codes
    localparam logic [DW-1:0] C_NOP    = 8'h00;
    localparam logic [DW-1:0] C_DEVRST = 8'h08;
    localparam logic [DW-1:0] C_PACKET = 8'hA0;
    localparam logic [DW-1:0] C_SETFT  = 8'hEF;

    // status bit positions
    localparam int S_BSY = 7;
    localparam int S_DRQ = 3;
    localparam int CTL_NIEN = 1;

    // fixed values
    localparam logic [DW-1:0] RV_ERR   = 8'h01;
    localparam logic [DW-1:0] RV_CNT   = 8'h01;
    localparam logic [DW-1:0] RV_BCLO  = 8'h14;
    localparam logic [DW-1:0] RV_BCHI  = 8'hEB;
    localparam logic [DW-1:0] ST_ABORT = 8'h51;
    localparam logic [DW-1:0] ER_ABORT = 8'h04;
    localparam logic [DW-1:0] ST_READY = 8'h50;
    localparam logic [DW-1:0] ST_XFER  = 8'h58;
    localparam logic [DW-1:0] CNT_CMDP = 8'h01;
    localparam logic [DW-1:0] CNT_DONE = 8'h03;
endpackage

// File: rtl/ata_tf_regs.sv
// Task-file register set and command decoder.
// Holds error, count, byte-count, feature, status, device and control, plus
// the transfer phase. Decodes command writes and the packet-engine handshake,
// and reports interrupt raise/clear requests to the interrupt unit.
// Assumes a single write per cycle and a combinational read path.
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          pkt_taken_i,
    input  logic          pkt_irq_i,
    input  logic          pkt_done_i,
    output logic          pkt_start_o,
    output logic          was_reset_o,
    output logic          raise_o,
    output logic          clear_o,
    output logic          nien_next_o,
    output logic          busy_o
);
    logic [DW-1:0] err_q, cnt_q, bclo_q, bchi_q, feat_q, stat_q, dev_q, ctl_q;
    phase_t        ph_q;
    logic          wasrst_q;
    logic          start_q;

    logic cmd_wr, do_rst, take_ok, done_ok, known;

    // decode command write and handshake qualifiers
    always_comb begin
        cmd_wr  = wr_en_i && (wr_addr_i == A_STATCMD);
        do_rst  = cmd_wr && (wr_data_i == C_DEVRST);
        take_ok = pkt_taken_i && (ph_q == PH_CMD);
        done_ok = pkt_done_i && (ph_q == PH_BUSY);
        known   = (wr_data_i == C_NOP) || (wr_data_i == C_DEVRST) ||
                  (wr_data_i == C_PACKET) || (wr_data_i == C_SETFT);
    end

    // task-file registers, phase and was-reset flag
    always_ff @(posedge clk) begin
        if (!rst_n || do_rst) begin
            err_q    <= RV_ERR;
            cnt_q    <= RV_CNT;
            bclo_q   <= RV_BCLO;
            bchi_q   <= RV_BCHI;
            feat_q   <= '0;
            stat_q   <= '0;
            dev_q    <= '0;
            ph_q     <= PH_IDLE;
            wasrst_q <= 1'b1;
        end else begin
            if (wr_en_i) begin
                case (wr_addr_i)
                    A_ERRFEAT: feat_q <= wr_data_i;
                    A_COUNT:   cnt_q  <= wr_data_i;
                    A_BCLO:    bclo_q <= wr_data_i;
                    A_BCHI:    bchi_q <= wr_data_i;
                    A_DEVICE:  dev_q  <= wr_data_i;
                    default: ;
                endcase
            end
            if (cmd_wr) begin
                case (wr_data_i)
                    C_NOP: begin
                        ph_q   <= PH_IDLE;
                        stat_q <= ST_ABORT;
                        err_q  <= ER_ABORT;
                    end
                    C_PACKET: begin
                        ph_q   <= PH_CMD;
                        stat_q <= ST_XFER;
                        err_q  <= {{(DW-2){1'b0}}, feat_q[1:0]};
                        cnt_q  <= CNT_CMDP;
                    end
                    C_SETFT: begin
                        stat_q <= ST_READY;
                        err_q  <= '0;
                        bclo_q <= '0;
                        bchi_q <= '0;
                    end
                    default: ;
                endcase
            end else if (take_ok) begin
                stat_q[S_BSY] <= 1'b1;
                stat_q[S_DRQ] <= 1'b0;
                ph_q          <= PH_BUSY;
            end else if (done_ok) begin
                stat_q   <= ST_READY;
                cnt_q    <= CNT_DONE;
                ph_q     <= PH_IDLE;
                wasrst_q <= 1'b0;
            end
        end
    end

    // control register survives the reset command
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en_i && wr_addr_i == A_ALTCTL)
            ctl_q <= wr_data_i;
    end

    // one-cycle start pulse to the packet engine
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= 1'b0;
        else
            start_q <= cmd_wr && (wr_data_i == C_PACKET);
    end

    // read mux
    always_comb begin
        case (rd_addr_i)
            A_ERRFEAT: rd_data_o = err_q;
            A_COUNT:   rd_data_o = cnt_q;
            A_BCLO:    rd_data_o = bclo_q;
            A_BCHI:    rd_data_o = bchi_q;
            A_DEVICE:  rd_data_o = dev_q;
            A_STATCMD: rd_data_o = stat_q;
            A_ALTCTL:  rd_data_o = stat_q;
            default:   rd_data_o = '0;
        endcase
    end

    // interrupt requests and next-state control bit
    always_comb begin
        raise_o = (cmd_wr && (wr_data_i == C_NOP || wr_data_i == C_SETFT)) ||
                  pkt_irq_i || done_ok;
        clear_o = cmd_wr ||
                  (rd_en_i && rd_addr_i == A_STATCMD && !stat_q[S_BSY]);
        nien_next_o = (wr_en_i && wr_addr_i == A_ALTCTL) ? wr_data_i[CTL_NIEN]
                                                         : ctl_q[CTL_NIEN];
    end

    assign pkt_start_o = start_q;
    assign was_reset_o = wasrst_q;
    assign busy_o      = stat_q[S_BSY];

    AST_NOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data_i == C_NOP |=> stat_q == ST_ABORT && err_q == ER_ABORT && ph_q == PH_IDLE); // R4
    AST_SETFT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data_i == C_SETFT |=> stat_q == ST_READY && err_q == '0 && bclo_q == '0); // R6
    AST_PKT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data_i == C_PACKET |=> pkt_start_o && stat_q == ST_XFER && ph_q == PH_CMD); // R7
    AST_PKT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start_o |=> !pkt_start_o || $past(cmd_wr)); // R7
    AST_UNKNOWN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !known |=> $stable(stat_q) && $stable(err_q) && $stable(ph_q)); // R11
endmodule

// File: rtl/ata_tf_irq.sv
// Pending-interrupt flag and masked host interrupt line.
// Raise wins over clear in the same cycle. The output is registered from the
// next-state flag and next-state disable bit, so it tracks both from the
// same clock edge. Assumes the request inputs are single-cycle decodes.
module ata_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic clear_i,
    input  logic nien_next_i,
    output logic pend_o,
    output logic irq_o
);
    logic pend_q, pend_d, irq_q;

    // next pending value
    always_comb begin
        if (raise_i)
            pend_d = 1'b1;
        else if (clear_i)
            pend_d = 1'b0;
        else
            pend_d = pend_q;
    end

    // pending flag and gated output line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= pend_d && !nien_next_i;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i |=> pend_q); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i && !raise_i |=> !pend_q && !irq_o); // R3
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_q); // R12
endmodule

// File: rtl/ata_taskfile_ctrl.sv
// Top level of the ATA device task-file controller: joins the register set
// and command decoder with the interrupt unit. Assumes one host access of
// each kind per cycle and a packet engine that follows the start/taken/done
// order.
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          pkt_start_o,
    input  logic          pkt_taken_i,
    input  logic          pkt_irq_i,
    input  logic          pkt_done_i,
    output logic          was_reset_o,
    output logic          irq_o
);
    logic raise, clear, nien_next, busy, pend;

    ata_tf_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .pkt_taken_i(pkt_taken_i), .pkt_irq_i(pkt_irq_i), .pkt_done_i(pkt_done_i),
        .pkt_start_o(pkt_start_o), .was_reset_o(was_reset_o),
        .raise_o(raise), .clear_o(clear), .nien_next_o(nien_next), .busy_o(busy)
    );

    ata_tf_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .raise_i(raise), .clear_i(clear), .nien_next_i(nien_next),
        .pend_o(pend), .irq_o(irq_o)
    );

    AST_BSY_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        pend && busy && rd_en_i && rd_addr_i == A_STATCMD && !wr_en_i |=> pend); // R10
endmodule

// File: tb/ata_taskfile_ctrl_bench.sv
// Bench: a vector table walked by one loop, then directed tests for the
// packet handshake, the reset command and the hardware reset.
module ata_taskfile_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pkt_start, pkt_taken = 1'b0, pkt_irq = 1'b0, pkt_done = 1'b0;
    logic       was_reset, irq;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ata_taskfile_ctrl u_ata_taskfile_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pkt_start_o(pkt_start), .pkt_taken_i(pkt_taken),
        .pkt_irq_i(pkt_irq), .pkt_done_i(pkt_done),
        .was_reset_o(was_reset), .irq_o(irq)
    );

    // vector: {kind[1:0], addr[2:0], data[7:0], req[3:0]}
    // kind 0 = write, 1 = read (status side effect) expect data, 2 = expect irq_o=data[0]
    localparam int NV = 40;
    localparam logic [16:0] VEC [NV] = '{
        {2'd0, 3'd1, 8'h5A, 4'd2},  // R2 count write
        {2'd1, 3'd1, 8'h5A, 4'd2},  // R2
        {2'd0, 3'd2, 8'h33, 4'd2},  // R2
        {2'd1, 3'd2, 8'h33, 4'd2},  // R2
        {2'd0, 3'd3, 8'hC4, 4'd2},  // R2
        {2'd1, 3'd3, 8'hC4, 4'd2},  // R2
        {2'd0, 3'd4, 8'hA0, 4'd2},  // R2
        {2'd1, 3'd4, 8'hA0, 4'd2},  // R2
        {2'd1, 3'd7, 8'h00, 4'd2},  // R2 unused address
        {2'd0, 3'd0, 8'h03, 4'd6},  // feature write
        {2'd0, 3'd5, 8'hEF, 4'd6},  // R6 set-features
        {2'd2, 3'd0, 8'h01, 4'd6},  // R6 irq raised
        {2'd1, 3'd0, 8'h00, 4'd6},  // R6
        {2'd1, 3'd2, 8'h00, 4'd6},  // R6
        {2'd1, 3'd3, 8'h00, 4'd6},  // R6
        {2'd1, 3'd1, 8'h5A, 4'd6},  // R6 count untouched
        {2'd1, 3'd5, 8'h50, 4'd6},  // R6 status, clears
        {2'd2, 3'd0, 8'h00, 4'd10}, // R10 cleared by status read
        {2'd0, 3'd5, 8'h00, 4'd4},  // R4 NOP
        {2'd2, 3'd0, 8'h01, 4'd4},  // R4
        {2'd1, 3'd0, 8'h04, 4'd4},  // R4
        {2'd1, 3'd6, 8'h51, 4'd4},  // R4 alt status
        {2'd2, 3'd0, 8'h01, 4'd10}, // R10 alt read keeps irq
        {2'd1, 3'd5, 8'h51, 4'd4},  // R4
        {2'd2, 3'd0, 8'h00, 4'd10}, // R10
        {2'd0, 3'd5, 8'h37, 4'd11}, // R11 unknown
        {2'd1, 3'd5, 8'h51, 4'd11}, // R11
        {2'd1, 3'd0, 8'h04, 4'd11}, // R11
        {2'd1, 3'd1, 8'h5A, 4'd11}, // R11
        {2'd0, 3'd5, 8'hEF, 4'd12}, // raise
        {2'd2, 3'd0, 8'h01, 4'd12}, // R12
        {2'd0, 3'd6, 8'h02, 4'd12}, // R12 disable
        {2'd2, 3'd0, 8'h00, 4'd12}, // R12
        {2'd0, 3'd6, 8'h00, 4'd12}, // R12 enable
        {2'd2, 3'd0, 8'h01, 4'd12}, // R12
        {2'd0, 3'd5, 8'h37, 4'd3},  // R3 command clears
        {2'd2, 3'd0, 8'h00, 4'd3},  // R3
        {2'd0, 3'd0, 8'h02, 4'd7},  // feature = 2
        {2'd0, 3'd5, 8'hA0, 4'd7},  // R7 packet
        {2'd1, 3'd5, 8'h58, 4'd7}   // R7
    };

    task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int req, input logic [2:0] a, input logic [7:0] exp);
        rd_en = 1'b1; rd_addr = a;
        #1 chk(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic reset_vals(input int req);
        rd(req, 3'd0, 8'h01);
        rd(req, 3'd1, 8'h01);
        rd(req, 3'd2, 8'h14);
        rd(req, 3'd3, 8'hEB);
        rd(req, 3'd4, 8'h00);
        rd(req, 3'd6, 8'h00);
        chk(req, {7'd0, was_reset}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(1, {7'd0, irq}, 8'h00);
        chk(1, {7'd0, pkt_start}, 8'h00);
        reset_vals(1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][16:15])
                2'd0: wr(VEC[i][14:12], VEC[i][11:4]);
                2'd1: rd(int'(VEC[i][3:0]), VEC[i][14:12], VEC[i][11:4]);
                default: chk(int'(VEC[i][3:0]), {7'd0, irq}, VEC[i][11:4]);
            endcase
        end
        // R7 error = feature[1:0], count = command phase
        rd(7, 3'd0, 8'h02);
        rd(7, 3'd1, 8'h01);

        // R7 start pulse width
        wr(3'd5, 8'hA0);
        chk(7, {7'd0, pkt_start}, 8'h01);
        @(negedge clk);
        chk(7, {7'd0, pkt_start}, 8'h00);
        // R8 taken
        pulse(pkt_taken);
        rd(8, 3'd6, 8'hD0);
        // R9 engine interrupt
        pulse(pkt_irq);
        chk(9, {7'd0, irq}, 8'h01);
        // R10 status read while BSY keeps irq
        rd(10, 3'd5, 8'hD0);
        chk(10, {7'd0, irq}, 8'h01);
        // R8 done
        pulse(pkt_done);
        rd(8, 3'd6, 8'h50);
        rd(8, 3'd1, 8'h03);
        chk(8, {7'd0, was_reset}, 8'h00);
        chk(8, {7'd0, irq}, 8'h01);
        rd(10, 3'd5, 8'h50);
        chk(10, {7'd0, irq}, 8'h00);

        // R5 reset command keeps control
        wr(3'd5, 8'hEF);
        wr(3'd6, 8'h02);
        wr(3'd1, 8'h77);
        wr(3'd5, 8'h08);
        reset_vals(5);
        chk(5, {7'd0, irq}, 8'h00);
        wr(3'd5, 8'hEF);
        chk(5, {7'd0, irq}, 8'h00);
        wr(3'd6, 8'h00);
        chk(5, {7'd0, irq}, 8'h01);

        // R1 hardware reset with irq pending
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(1, {7'd0, irq}, 8'h00);
        reset_vals(1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule